// File: doc/BRIEF.md
# Single-Bus Micro-Operation Sequencer

This block is the hardwired control state machine for a processor datapath built around one shared internal bus. That bus links the general register file, the memory address register (MAR), the memory data register (MDR), the ALU holding register Y, the ALU result register Z, an ALU operand-A latch, a branch-target source and the program counter. The sequencer receives an instruction that has already been decoded. It then walks through the register-transfer steps for that instruction, driving one bus source enable and one destination load enable per bus cycle. It also holds the fixed-length waits for memory (5 cycles) and for the ALU (2 cycles).

Three instruction kinds are sequenced:
- A memory-operand add, `ra <= ra + M[rb]`.
- A register load, `rb <= M[ra]`.
- A branch-on-not-equal, which compares `ra` with `rb` and then either loads the branch target into the PC or increments the PC.

Commands arrive on a valid/ready handshake. `cmd_ready` is high only while the sequencer is idle. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. The source must hold `cmd_op`, `cmd_ra` and `cmd_rb` stable until that edge. While an instruction is running, `cmd_ready` stays low and any offered command waits. After the final transfer, `done` pulses for one cycle and the sequencer returns to idle.

Top module: `sbus_useq`

## Requirements
- R1: `cmd_ready` is high exactly when the sequencer is idle. While idle, no bus source, no destination, `mem_rd`, `alu_go`, `pc_inc` or `done` is active. Opcodes are: 0 memory add, 1 load, 2 branch-on-not-equal, 3 reserved.
- R2: At most one bit of `bus_src` is high in any cycle. The bits are: bit0 register file, bit1 MDR, bit2 Z, bit3 branch target. The `bus_dst` bits are: bit0 register file, bit1 MAR, bit2 Y, bit3 ALU A, bit4 ALU B (loaded from Y on a side path, no bus source), bit5 PC.
- R3: A memory add occupies 12 cycles after acceptance, in this order:
  - 1 cycle: reg[rb] to MAR.
  - 5 cycles: memory read.
  - 1 cycle: MDR to Y.
  - 1 cycle: reg[ra] to A.
  - 1 cycle: Y to B.
  - 2 cycles: ALU add (`alu_sub`=0).
  - 1 cycle: Z to reg[ra].
- R4: A load occupies 7 cycles: 1 cycle reg[ra] to MAR, 5 cycles memory read, then 1 cycle MDR to reg[rb].
- R5: A branch runs reg[ra] to Y, reg[rb] to A, Y to B, then 2 ALU cycles with `alu_sub`=1. In the decision cycle that follows, if `alu_zero` is 0, the branch target drives the bus into the PC.
- R6: If `alu_zero` is 1 in the branch decision cycle, `pc_inc` pulses and the PC destination stays low.
- R7: `mem_rd` stays high for exactly 5 consecutive cycles for each memory step.
- R8: `alu_go` stays high for exactly 2 consecutive cycles for each ALU step, and `z_load` is high only in the last of those cycles.
- R9: `done` is high for exactly one cycle, directly after the final transfer, and `cmd_ready` is high in the next cycle.
- R10: Reset (active-low, asynchronous) returns the sequencer to idle with all enables low, even in the middle of an instruction.
- R11: The reserved opcode 3 performs no transfer: `done` pulses in the first cycle after acceptance.
- R12: A command offered while the sequencer is busy is neither accepted nor allowed to disturb the running sequence. It is accepted on the first idle edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Decoded instruction offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_op | input | 2 | Instruction kind |
| cmd_ra | input | RW | First register index |
| cmd_rb | input | RW | Second register index |
| alu_zero | input | 1 | ALU zero flag from the datapath |
| bus_src | output | 4 | One-hot bus source enables |
| bus_dst | output | 6 | Destination load enables |
| reg_sel | output | RW | Register index for a register-file transfer |
| mem_rd | output | 1 | Memory read in progress |
| alu_go | output | 1 | ALU operation in progress |
| alu_sub | output | 1 | ALU subtracts (valid with alu_go) |
| z_load | output | 1 | Z captures the ALU result |
| pc_inc | output | 1 | PC increments |
| done | output | 1 | Instruction finished |

## Verification
The bench compares every cycle of each sequence against a per-step model. Any design that miscounts a wait would shift all later transfers, so a 4- or 6-cycle memory step or a 1-cycle ALU step shows up as a mismatch in the step right after it. Register-index mixups are also caught: a design that addresses MAR with `ra` on a memory add, or writes the load result back to `ra`, drives the wrong `reg_sel`. The branch is run with both flag values, so a design that inverts the zero test loads the PC on equal operands instead of incrementing it. A command held valid across a whole instruction, and a reset applied in the middle of a memory wait, check that a busy sequencer neither restarts nor keeps enables asserted.

// File: rtl/sbseq_pkg.sv
package sbseq_pkg;
  typedef enum logic [1:0] {
    OP_ADDM = 2'd0,
    OP_LOAD = 2'd1,
    OP_BNE  = 2'd2,
    OP_NOP  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_MAR, S_MEM, S_MDR2Y, S_MDR2R, S_YLD,
    S_ALD, S_BLD, S_ALU, S_ZWB, S_BR, S_DONE
  } st_e;

  localparam int SRC_GPR = 0;
  localparam int SRC_MDR = 1;
  localparam int SRC_Z   = 2;
  localparam int SRC_TGT = 3;
  localparam int NSRC    = 4;

  localparam int DST_GPR = 0;
  localparam int DST_MAR = 1;
  localparam int DST_Y   = 2;
  localparam int DST_A   = 3;
  localparam int DST_B   = 4;
  localparam int DST_PC  = 5;
  localparam int NDST    = 6;
endpackage

// File: rtl/useq_timer.sv
module useq_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/useq_next.sv
module useq_next
  import sbseq_pkg::*;
(
  input  st_e        st,
  input  logic       accept,
  input  logic [1:0] new_op,
  input  logic [1:0] cur_op,
  input  logic       last,
  output st_e        nxt
);
  always_comb begin
    nxt = st;
    unique case (st)
      S_IDLE: if (accept) begin
        unique case (op_e'(new_op))
          OP_ADDM, OP_LOAD: nxt = S_MAR;
          OP_BNE:           nxt = S_YLD;
          default:          nxt = S_DONE;
        endcase
      end
      S_MAR:   nxt = S_MEM;
      S_MEM:   if (last) nxt = (op_e'(cur_op) == OP_LOAD) ? S_MDR2R : S_MDR2Y;
      S_MDR2Y: nxt = S_ALD;
      S_MDR2R: nxt = S_DONE;
      S_YLD:   nxt = S_ALD;
      S_ALD:   nxt = S_BLD;
      S_BLD:   nxt = S_ALU;
      S_ALU:   if (last) nxt = (op_e'(cur_op) == OP_BNE) ? S_BR : S_ZWB;
      S_ZWB:   nxt = S_DONE;
      S_BR:    nxt = S_DONE;
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end
endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import sbseq_pkg::*;
#(
  parameter int RW = 3
) (
  input  st_e              st,
  input  logic [1:0]       op,
  input  logic [RW-1:0]    ra,
  input  logic [RW-1:0]    rb,
  input  logic             zero,
  input  logic             last,
  output logic [NSRC-1:0]  src,
  output logic [NDST-1:0]  dst,
  output logic [RW-1:0]    sel,
  output logic             mem_rd,
  output logic             alu_go,
  output logic             alu_sub,
  output logic             z_load,
  output logic             pc_inc,
  output logic             done
);
  always_comb begin
    src = '0; dst = '0; sel = '0;
    mem_rd = 1'b0; alu_go = 1'b0; alu_sub = 1'b0;
    z_load = 1'b0; pc_inc = 1'b0; done = 1'b0;
    unique case (st)
      S_MAR: begin
        src[SRC_GPR] = 1'b1; dst[DST_MAR] = 1'b1;
        sel = (op_e'(op) == OP_ADDM) ? rb : ra;
      end
      S_MEM:   mem_rd = 1'b1;
      S_MDR2Y: begin src[SRC_MDR] = 1'b1; dst[DST_Y] = 1'b1; end
      S_MDR2R: begin src[SRC_MDR] = 1'b1; dst[DST_GPR] = 1'b1; sel = rb; end
      S_YLD:   begin src[SRC_GPR] = 1'b1; dst[DST_Y] = 1'b1; sel = ra; end
      S_ALD: begin
        src[SRC_GPR] = 1'b1; dst[DST_A] = 1'b1;
        sel = (op_e'(op) == OP_BNE) ? rb : ra;
      end
      S_BLD:   dst[DST_B] = 1'b1;
      S_ALU: begin
        alu_go  = 1'b1;
        alu_sub = (op_e'(op) == OP_BNE);
        z_load  = last;
      end
      S_ZWB:   begin src[SRC_Z] = 1'b1; dst[DST_GPR] = 1'b1; sel = ra; end
      S_BR: begin
        if (!zero) begin src[SRC_TGT] = 1'b1; dst[DST_PC] = 1'b1; end
        else       pc_inc = 1'b1;
      end
      S_DONE:  done = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sbus_useq.sv
module sbus_useq
  import sbseq_pkg::*;
#(
  parameter int NREG    = 8,
  parameter int MEM_LAT = 5,
  parameter int ALU_LAT = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [1:0]                cmd_op,
  input  logic [$clog2(NREG)-1:0]   cmd_ra,
  input  logic [$clog2(NREG)-1:0]   cmd_rb,
  input  logic                      alu_zero,
  output logic [3:0]                bus_src,
  output logic [5:0]                bus_dst,
  output logic [$clog2(NREG)-1:0]   reg_sel,
  output logic                      mem_rd,
  output logic                      alu_go,
  output logic                      alu_sub,
  output logic                      z_load,
  output logic                      pc_inc,
  output logic                      done
);
  localparam int RW   = $clog2(NREG);
  localparam int LMAX = (MEM_LAT > ALU_LAT) ? MEM_LAT : ALU_LAT;
  localparam int CW   = $clog2(LMAX + 1);

  st_e           st_q, st_d;
  logic [1:0]    op_q;
  logic [RW-1:0] ra_q, rb_q;
  logic          accept, last, tmr_load;
  logic [CW-1:0] tmr_val;

  assign cmd_ready = (st_q == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      op_q <= '0;
      ra_q <= '0;
      rb_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        op_q <= cmd_op;
        ra_q <= cmd_ra;
        rb_q <= cmd_rb;
      end
    end
  end

  useq_next u_next (
    .st(st_q), .accept(accept), .new_op(cmd_op), .cur_op(op_q),
    .last(last), .nxt(st_d)
  );

  assign tmr_load = (st_d != st_q) && ((st_d == S_MEM) || (st_d == S_ALU));
  assign tmr_val  = (st_d == S_MEM) ? CW'(MEM_LAT - 1) : CW'(ALU_LAT - 1);

  useq_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .last(last)
  );

  useq_decode #(.RW(RW)) u_dec (
    .st(st_q), .op(op_q), .ra(ra_q), .rb(rb_q), .zero(alu_zero), .last(last),
    .src(bus_src), .dst(bus_dst), .sel(reg_sel), .mem_rd(mem_rd),
    .alu_go(alu_go), .alu_sub(alu_sub), .z_load(z_load),
    .pc_inc(pc_inc), .done(done)
  );
endmodule

// File: rtl/sbus_useq_chk.sv
module sbus_useq_chk #(
  parameter int MEM_LAT = 5,
  parameter int ALU_LAT = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_ready,
  input logic [3:0] bus_src,
  input logic [5:0] bus_dst,
  input logic       mem_rd,
  input logic       alu_go,
  input logic       z_load,
  input logic       pc_inc,
  input logic       done
);
  int unsigned mrun, arun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrun <= 0;
      arun <= 0;
    end else begin
      mrun <= mem_rd ? mrun + 1 : 0;
      arun <= alu_go ? arun + 1 : 0;
    end
  end

  assert_bus_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_src));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (bus_src == 4'b0 && bus_dst == 6'b0 && !mem_rd && !alu_go && !pc_inc && !done));

  assert_gpr_write_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dst[0] |-> (bus_src[1] || bus_src[2]));

  assert_mem_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd && mrun != 0) |-> (mrun == MEM_LAT));

  assert_mem_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mrun <= MEM_LAT);

  assert_alu_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_go && arun != 0) |-> (arun == ALU_LAT));

  assert_zload_in_alu_R8: assert property (@(posedge clk) disable iff (!rst_n)
    z_load |-> (alu_go && arun == ALU_LAT - 1));

  assert_pc_choice_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_inc && bus_dst[5]));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));
endmodule

bind sbus_useq sbus_useq_chk #(.MEM_LAT(MEM_LAT), .ALU_LAT(ALU_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .bus_src(bus_src),
  .bus_dst(bus_dst), .mem_rd(mem_rd), .alu_go(alu_go), .z_load(z_load),
  .pc_inc(pc_inc), .done(done)
);

// File: tb/sbus_useq_tb.sv
module sbus_useq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [2:0] cmd_ra = '0, cmd_rb = '0;
  logic alu_zero = 1'b0;
  logic [3:0] bus_src;
  logic [5:0] bus_dst;
  logic [2:0] reg_sel;
  logic mem_rd, alu_go, alu_sub, z_load, pc_inc, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sbus_useq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_ra(cmd_ra), .cmd_rb(cmd_rb), .alu_zero(alu_zero),
    .bus_src(bus_src), .bus_dst(bus_dst), .reg_sel(reg_sel), .mem_rd(mem_rd),
    .alu_go(alu_go), .alu_sub(alu_sub), .z_load(z_load), .pc_inc(pc_inc),
    .done(done)
  );

  // {op, ra, rb, zero}
  localparam logic [8:0] VEC [0:7] = '{
    {2'd0, 3'd1, 3'd2, 1'b0},
    {2'd0, 3'd7, 3'd0, 1'b1},
    {2'd1, 3'd1, 3'd2, 1'b0},
    {2'd1, 3'd5, 3'd5, 1'b0},
    {2'd2, 3'd3, 3'd4, 1'b0},
    {2'd2, 3'd2, 3'd2, 1'b1},
    {2'd3, 3'd6, 3'd1, 1'b0},
    {2'd2, 3'd0, 3'd7, 1'b0}
  };

  // {src[3:0], dst[5:0], mem_rd, alu_go, alu_sub, z_load, pc_inc, done}
  function automatic logic [15:0] exp_step(input logic [1:0] op, input logic zero, input int k);
    logic [3:0] s; logic [5:0] d; logic m, a, sb, z, pi, dn;
    s = '0; d = '0; m = 0; a = 0; sb = 0; z = 0; pi = 0; dn = 0;
    case (op)
      2'd0: begin
        if (k == 0) begin s[0] = 1; d[1] = 1; end
        else if (k <= 5) m = 1;
        else if (k == 6) begin s[1] = 1; d[2] = 1; end
        else if (k == 7) begin s[0] = 1; d[3] = 1; end
        else if (k == 8) d[4] = 1;
        else if (k <= 10) begin a = 1; z = (k == 10); end
        else if (k == 11) begin s[2] = 1; d[0] = 1; end
        else dn = 1;
      end
      2'd1: begin
        if (k == 0) begin s[0] = 1; d[1] = 1; end
        else if (k <= 5) m = 1;
        else if (k == 6) begin s[1] = 1; d[0] = 1; end
        else dn = 1;
      end
      2'd2: begin
        if (k == 0) begin s[0] = 1; d[2] = 1; end
        else if (k == 1) begin s[0] = 1; d[3] = 1; end
        else if (k == 2) d[4] = 1;
        else if (k <= 4) begin a = 1; sb = 1; z = (k == 4); end
        else if (k == 5) begin
          if (!zero) begin s[3] = 1; d[5] = 1; end else pi = 1;
        end
        else dn = 1;
      end
      default: dn = 1;
    endcase
    return {s, d, m, a, sb, z, pi, dn};
  endfunction

  function automatic logic [2:0] exp_sel(input logic [1:0] op, input logic [2:0] ra, rb, input int k);
    case (op)
      2'd0: return (k == 0) ? rb : ra;
      2'd1: return (k == 0) ? ra : rb;
      default: return (k == 0) ? ra : rb;
    endcase
  endfunction

  function automatic int exp_len(input logic [1:0] op);
    case (op)
      2'd0: return 12;
      2'd1: return 7;
      2'd2: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] op, input logic zero);
    case (op)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return zero ? "R6" : "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [2:0] ra, rb, input logic zero);
    logic [15:0] act, e;
    int memc, aluc;
    memc = 0; aluc = 0;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R1", "ready before issue", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_op = op; cmd_ra = ra; cmd_rb = rb; alu_zero = zero;
    for (int k = 0; k <= exp_len(op); k++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      act = {bus_src, bus_dst, mem_rd, alu_go, alu_sub, z_load, pc_inc, done};
      e = exp_step(op, zero, k);
      check(act == e, req_of(op, zero), $sformatf("step %0d controls", k), act, e);
      check($countones(bus_src) <= 1, "R2", "bus sources", bus_src, 0);
      if (e[15:12] == 4'b0001 || e[6]) begin
        check(reg_sel == exp_sel(op, ra, rb, k), req_of(op, zero),
              $sformatf("step %0d reg_sel", k), reg_sel, exp_sel(op, ra, rb, k));
      end
      if (mem_rd) memc++;
      if (alu_go) aluc++;
    end
    if (op == 2'd0 || op == 2'd1)
      check(memc == 5, "R7", "memory cycles", memc, 5);
    if (op == 2'd0 || op == 2'd2)
      check(aluc == 2, "R8", "alu cycles", aluc, 2);
    @(negedge clk);
    check(cmd_ready == 1'b1 && done == 1'b0, "R9", "ready after done",
          {cmd_ready, done}, 2'b10);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    #1;
    check(cmd_ready && bus_src == 0 && bus_dst == 0 && !mem_rd && !alu_go && !done,
          "R10", "reset outputs", {bus_src, bus_dst}, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready && bus_src == 0 && bus_dst == 0 && !pc_inc && !done,
          "R1", "idle after reset", {cmd_ready, bus_src, bus_dst}, 11'h400);

    for (int i = 0; i < 8; i++) begin
      run_cmd(VEC[i][8:7], VEC[i][6:4], VEC[i][3:1], VEC[i][0]);
    end

    // R12: valid held through a whole load; must not restart it
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_ra = 3'd3; cmd_rb = 3'd6;
    for (int k = 0; k <= 7; k++) begin
      @(negedge clk);
      if (k == 0) check(cmd_ready == 1'b0, "R12", "busy ready low", cmd_ready, 0);
      if (k == 3) check(mem_rd == 1'b1, "R12", "read continues", mem_rd, 1);
    end
    check(done == 1'b1, "R12", "first load completes", done, 1);
    @(negedge clk);
    check(cmd_ready == 1'b1, "R12", "idle between commands", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(bus_dst == 6'b000010 && reg_sel == 3'd3, "R12", "second command taken",
          {bus_dst, reg_sel}, {6'b000010, 3'd3});
    for (int k = 0; k < 7; k++) @(negedge clk);
    check(done == 1'b1, "R12", "second load completes", done, 1);
    @(negedge clk);

    // R10: reset in the middle of a memory wait
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_ra = 3'd1; cmd_rb = 3'd2;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    check(mem_rd == 1'b1, "R10", "mid-run read active", mem_rd, 1);
    rst_n = 1'b0;
    #1;
    check(cmd_ready && !mem_rd && bus_src == 0 && bus_dst == 0, "R10", "reset mid-run",
          {cmd_ready, mem_rd}, 2'b10);
    @(negedge clk);
    rst_n = 1'b1;
    run_cmd(2'd2, 3'd4, 3'd5, 1'b1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule